// File: doc/BRIEF.md
# Cell protection control state machine

This block is the digital supervisor of a single-cell battery protector. It receives already-synchronised comparator flags and two presence indications, charger and load. From them it decides whether the charge switch and the discharge switch may conduct. It also decides when the analog bias may be switched off and which weak bias the current-sense line receives. A fault takes effect only after its flag has stayed asserted for a fault-specific number of timing ticks. A fault is cleared only after two things: the charger or load that caused it has gone away, and a release flag has held for its own qualification time.

Two free-running tick strobes pace the delay counters, one per millisecond and one per microsecond. All delays are parameters counted in ticks. The short-circuit detect delay and the under-voltage release delay use the microsecond strobe. Every other delay uses the millisecond strobe. A mode register selects which detectors may run: in normal mode all five fault detectors are armed, while each fault mode arms only its own release path. A fault mode may arm one more detector. In over-charge that is the short-circuit detector, so it can still take the discharge switch away.

Top module: `cellprot_ctrl`

## Requirements
- R1: After reset the block is in normal mode. The output vector {chg_en, dsg_en, shutdown, cs_pulldown, cs_pullup} reads 11000.
- R2: In normal mode a detect flag moves the block into its fault mode only after it has been sampled high for its full tick count on consecutive ticks. If it drops earlier, its count restarts from zero. The fault modes show these output vectors: over-charge 01000, under-voltage 10101, discharge over-current or short-circuit 10010, charge over-current 01000.
- R3: Over-charge is left for normal mode only after the over-charge release flag has held for its count on ticks where the charger is absent. While the charger is present the mode holds.
- R4: In over-charge mode the discharge over-current flag has no effect. A short-circuit flag held for its count leads to 00010. That mode returns to over-charge (01000) on the first edge at which both the load and the short-circuit flag are low.
- R5: Under-voltage keeps shutdown and the pull-up asserted until a charger is seen. On the edge after the charger appears the outputs read 10000. The block returns to normal once the under-voltage release flag has held for its count. Until then the charge over-current flag has no effect.
- R6: Either discharge fault is left for normal mode only after the discharge release flag has held for its count while the load is absent. While the load is present the mode holds.
- R7: Charge over-current is left for normal mode only after the charge release flag has held for its count while the charger is absent.
- R8: While low_cell is high, chg_en is low in every mode. The other outputs are unchanged.
- R9: When several detectors reach their counts on the same edge, the winner is chosen in this order: short-circuit, discharge over-current, under-voltage, charge over-current, over-charge.
- R10: A delay counter advances only on an edge where its own tick strobe is high. Short-circuit detect and under-voltage release use us_tick; all other delays use ms_tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ms_tick | input | 1 | Millisecond strobe, one clock wide |
| us_tick | input | 1 | Microsecond strobe, one clock wide |
| ov_trip | input | 1 | Cell at or above over-charge level |
| ov_clear | input | 1 | Cell below over-charge release level |
| uv_trip | input | 1 | Cell below under-voltage level |
| uv_clear | input | 1 | Cell above under-voltage release level |
| doc_trip | input | 1 | Discharge current above over-current level |
| short_trip | input | 1 | Discharge current above short-circuit level |
| doc_clear | input | 1 | Sense line below discharge release level |
| coc_trip | input | 1 | Charge current above over-current level |
| coc_clear | input | 1 | Sense line above charge release level |
| low_cell | input | 1 | Cell too low to accept charge |
| charger_on | input | 1 | Charger connected |
| load_on | input | 1 | Load connected |
| chg_en | output | 1 | Charge switch enable |
| dsg_en | output | 1 | Discharge switch enable |
| shutdown | output | 1 | Analog bias off |
| cs_pulldown | output | 1 | Sense-line pull-down select |
| cs_pullup | output | 1 | Sense-line pull-up select |

## Verification
The hardest states to reach are the ones nested behind another fault. Short-circuit inside over-charge needs two qualified detections in a row. The charge over-current lockout is only observable during the wake phase of under-voltage. The bench walks there step by step, with every delay shortened to a few ticks. Priority between two faults that drive the same outputs is decided by which release flag later frees the block. The tick-gating check holds a flag high with the strobe idle, then counts single strobes up to the limit.

// File: rtl/cellprot_pkg.sv
package cellprot_pkg;

  typedef enum logic [2:0] {
    M_NORMAL  = 3'd0,
    M_OVCHG   = 3'd1,
    M_OVSC    = 3'd2,
    M_DSGOC   = 3'd3,
    M_UVSLEEP = 3'd4,
    M_UVWAKE  = 3'd5,
    M_CHGOC   = 3'd6
  } mode_e;

  // Timer slots; detect slots are listed in priority order.
  localparam int T_SC  = 0;
  localparam int T_DOC = 1;
  localparam int T_UV  = 2;
  localparam int T_COC = 3;
  localparam int T_OV  = 4;
  localparam int T_OVR = 5;
  localparam int T_UVR = 6;
  localparam int T_DR  = 7;
  localparam int T_CR  = 8;
  localparam int NT    = 9;

  typedef struct packed {
    logic ov;
    logic ovr;
    logic uv;
    logic uvr;
    logic doc;
    logic sc;
    logic dr;
    logic coc;
    logic cr;
    logic charger;
    logic load;
  } flags_t;

  typedef struct packed {
    logic chg;
    logic dsg;
    logic shdn;
    logic pd;
    logic pu;
  } drive_t;

endpackage

// File: rtl/cellprot_qual.sv
module cellprot_qual #(
  parameter int unsigned LIMIT = 4,
  parameter int unsigned CW    = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic tick,
  output logic hit
);

  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  assign hit    = arm & tick & (cnt_q == LAST);
  assign cnt_en = ~arm | tick;

  always_comb begin
    cnt_d = cnt_q;
    if (!arm)      cnt_d = '0;
    else if (hit)  cnt_d = '0;
    else           cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

endmodule

// File: rtl/cellprot_fsm.sv
module cellprot_fsm
  import cellprot_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  flags_t          flg,
  input  logic [NT-1:0]   hit,
  output logic [NT-1:0]   arm,
  output mode_e           mode
);

  mode_e mode_q;
  mode_e mode_d;

  logic in_norm;
  logic in_ov;

  assign in_norm = (mode_q == M_NORMAL);
  assign in_ov   = (mode_q == M_OVCHG);

  always_comb begin
    arm        = '0;
    arm[T_SC]  = (in_norm | in_ov) & flg.sc;
    arm[T_DOC] = in_norm & flg.doc;
    arm[T_UV]  = in_norm & flg.uv;
    arm[T_COC] = in_norm & flg.coc;
    arm[T_OV]  = in_norm & flg.ov;
    arm[T_OVR] = in_ov & flg.ovr & ~flg.charger;
    arm[T_UVR] = (mode_q == M_UVWAKE) & flg.uvr;
    arm[T_DR]  = (mode_q == M_DSGOC) & flg.dr & ~flg.load;
    arm[T_CR]  = (mode_q == M_CHGOC) & flg.cr & ~flg.charger;
  end

  always_comb begin
    mode_d = mode_q;
    unique case (mode_q)
      M_NORMAL: begin
        if      (hit[T_SC])  mode_d = M_DSGOC;
        else if (hit[T_DOC]) mode_d = M_DSGOC;
        else if (hit[T_UV])  mode_d = M_UVSLEEP;
        else if (hit[T_COC]) mode_d = M_CHGOC;
        else if (hit[T_OV])  mode_d = M_OVCHG;
      end
      M_OVCHG: begin
        if      (hit[T_SC])  mode_d = M_OVSC;
        else if (hit[T_OVR]) mode_d = M_NORMAL;
      end
      M_OVSC: begin
        if (!flg.load && !flg.sc) mode_d = M_OVCHG;
      end
      M_DSGOC: begin
        if (hit[T_DR]) mode_d = M_NORMAL;
      end
      M_UVSLEEP: begin
        if (flg.charger) mode_d = M_UVWAKE;
      end
      M_UVWAKE: begin
        if (hit[T_UVR]) mode_d = M_NORMAL;
      end
      M_CHGOC: begin
        if (hit[T_CR]) mode_d = M_NORMAL;
      end
      default: mode_d = M_NORMAL;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= M_NORMAL;
    else        mode_q <= mode_d;
  end

  assign mode = mode_q;

endmodule

// File: rtl/cellprot_outmap.sv
module cellprot_outmap
  import cellprot_pkg::*;
(
  input  mode_e  mode,
  input  logic   inhibit,
  output drive_t drv
);

  drive_t base;

  always_comb begin
    unique case (mode)
      M_NORMAL:  base = '{chg: 1'b1, dsg: 1'b1, shdn: 1'b0, pd: 1'b0, pu: 1'b0};
      M_OVCHG:   base = '{chg: 1'b0, dsg: 1'b1, shdn: 1'b0, pd: 1'b0, pu: 1'b0};
      M_OVSC:    base = '{chg: 1'b0, dsg: 1'b0, shdn: 1'b0, pd: 1'b1, pu: 1'b0};
      M_DSGOC:   base = '{chg: 1'b1, dsg: 1'b0, shdn: 1'b0, pd: 1'b1, pu: 1'b0};
      M_UVSLEEP: base = '{chg: 1'b1, dsg: 1'b0, shdn: 1'b1, pd: 1'b0, pu: 1'b1};
      M_UVWAKE:  base = '{chg: 1'b1, dsg: 1'b0, shdn: 1'b0, pd: 1'b0, pu: 1'b0};
      M_CHGOC:   base = '{chg: 1'b0, dsg: 1'b1, shdn: 1'b0, pd: 1'b0, pu: 1'b0};
      default:   base = '{chg: 1'b1, dsg: 1'b1, shdn: 1'b0, pd: 1'b0, pu: 1'b0};
    endcase
  end

  always_comb begin
    drv     = base;
    drv.chg = base.chg & ~inhibit;
  end

endmodule

// File: rtl/cellprot_ctrl.sv
module cellprot_ctrl
  import cellprot_pkg::*;
#(
  parameter int unsigned SC_TICKS  = 200,
  parameter int unsigned DOC_TICKS = 12,
  parameter int unsigned UV_TICKS  = 20,
  parameter int unsigned COC_TICKS = 16,
  parameter int unsigned OV_TICKS  = 1000,
  parameter int unsigned OVR_TICKS = 16,
  parameter int unsigned UVR_TICKS = 1100,
  parameter int unsigned DR_TICKS  = 4,
  parameter int unsigned CR_TICKS  = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ms_tick,
  input  logic us_tick,
  input  logic ov_trip,
  input  logic ov_clear,
  input  logic uv_trip,
  input  logic uv_clear,
  input  logic doc_trip,
  input  logic short_trip,
  input  logic doc_clear,
  input  logic coc_trip,
  input  logic coc_clear,
  input  logic low_cell,
  input  logic charger_on,
  input  logic load_on,
  output logic chg_en,
  output logic dsg_en,
  output logic shutdown,
  output logic cs_pulldown,
  output logic cs_pullup
);

  localparam int unsigned LIM [NT] = '{SC_TICKS, DOC_TICKS, UV_TICKS, COC_TICKS,
                                       OV_TICKS, OVR_TICKS, UVR_TICKS, DR_TICKS,
                                       CR_TICKS};
  localparam bit FAST [NT] = '{1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0};

  function automatic int unsigned lim_max();
    int unsigned m = 1;
    for (int i = 0; i < NT; i++) if (LIM[i] > m) m = LIM[i];
    return m;
  endfunction

  localparam int unsigned CW = $clog2(lim_max() + 1);

  // Reset: asynchronous assert, two-flop synchronous release
  logic rst_meta;
  logic rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_q    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_q    <= rst_meta;
    end
  end

  flags_t        flg;
  logic [NT-1:0] arm;
  logic [NT-1:0] hit;
  mode_e         mode_q;
  drive_t        drv;

  assign flg = '{ov: ov_trip, ovr: ov_clear, uv: uv_trip, uvr: uv_clear,
                 doc: doc_trip, sc: short_trip, dr: doc_clear, coc: coc_trip,
                 cr: coc_clear, charger: charger_on, load: load_on};

  for (genvar g = 0; g < NT; g++) begin : g_qual
    logic tk;
    if (FAST[g]) begin : g_us
      assign tk = us_tick;
    end else begin : g_ms
      assign tk = ms_tick;
    end
    cellprot_qual #(.LIMIT(LIM[g]), .CW(CW)) u_qual (
      .clk   (clk),
      .rst_n (rst_q),
      .arm   (arm[g]),
      .tick  (tk),
      .hit   (hit[g])
    );
  end

  cellprot_fsm u_fsm (
    .clk   (clk),
    .rst_n (rst_q),
    .flg   (flg),
    .hit   (hit),
    .arm   (arm),
    .mode  (mode_q)
  );

  cellprot_outmap u_out (
    .mode    (mode_q),
    .inhibit (low_cell),
    .drv     (drv)
  );

  assign chg_en      = drv.chg;
  assign dsg_en      = drv.dsg;
  assign shutdown    = drv.shdn;
  assign cs_pulldown = drv.pd;
  assign cs_pullup   = drv.pu;

endmodule

// File: rtl/cellprot_chk.sv
module cellprot_chk
  import cellprot_pkg::*;
(
  input logic  clk,
  input logic  rst_q,
  input logic  ms_tick,
  input logic  us_tick,
  input logic  ov_trip,
  input logic  uv_trip,
  input logic  coc_trip,
  input logic  low_cell,
  input logic  charger_on,
  input logic  chg_en,
  input logic  dsg_en,
  input logic  shutdown,
  input logic  cs_pulldown,
  input mode_e mode_q
);

  // R3
  chg_cut_cause_chk: assert property (@(posedge clk) disable iff (!rst_q)
    ($past(chg_en && dsg_en && !low_cell) && !chg_en && dsg_en && !low_cell)
      |-> $past(ov_trip || coc_trip));

  // R5
  shdn_entry_chk: assert property (@(posedge clk) disable iff (!rst_q)
    $rose(shutdown) |-> $past(uv_trip));

  // R5
  shdn_exit_chk: assert property (@(posedge clk) disable iff (!rst_q)
    $fell(shutdown) |-> $past(charger_on));

  // R5
  wake_no_coc_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (mode_q == M_UVWAKE) |=> (mode_q != M_CHGOC));

  // R4
  ovsc_origin_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (mode_q == M_OVSC && $past(mode_q) != M_OVSC) |-> ($past(mode_q) == M_OVCHG));

  // R6
  pulldown_dsg_off_chk: assert property (@(posedge clk) disable iff (!rst_q)
    cs_pulldown |-> !dsg_en);

  // R10
  no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (!ms_tick && !us_tick && mode_q == M_NORMAL) |=> (mode_q == M_NORMAL));

endmodule

bind cellprot_ctrl cellprot_chk u_chk (
  .clk        (clk),
  .rst_q      (rst_q),
  .ms_tick    (ms_tick),
  .us_tick    (us_tick),
  .ov_trip    (ov_trip),
  .uv_trip    (uv_trip),
  .coc_trip   (coc_trip),
  .low_cell   (low_cell),
  .charger_on (charger_on),
  .chg_en     (chg_en),
  .dsg_en     (dsg_en),
  .shutdown   (shutdown),
  .cs_pulldown(cs_pulldown),
  .mode_q     (mode_q)
);

// File: tb/tb_cellprot_ctrl.sv
module tb_cellprot_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int L_SC  = 2;
  localparam int L_DOC = 4;
  localparam int L_UV  = 4;
  localparam int L_COC = 4;
  localparam int L_OV  = 4;
  localparam int L_OVR = 3;
  localparam int L_UVR = 3;
  localparam int L_DR  = 3;
  localparam int L_CR  = 3;

  localparam logic [4:0] O_NORM = 5'b11000;
  localparam logic [4:0] O_OV   = 5'b01000;
  localparam logic [4:0] O_OVSC = 5'b00010;
  localparam logic [4:0] O_DSG  = 5'b10010;
  localparam logic [4:0] O_UVS  = 5'b10101;
  localparam logic [4:0] O_UVW  = 5'b10000;
  localparam logic [4:0] O_COC  = 5'b01000;

  logic clk = 1'b0;
  logic rst_n;
  logic ms_tick, us_tick;
  logic ov_trip, ov_clear, uv_trip, uv_clear, doc_trip, short_trip, doc_clear;
  logic coc_trip, coc_clear, low_cell, charger_on, load_on;
  logic chg_en, dsg_en, shutdown, cs_pulldown, cs_pullup;

  int nvec = 0;
  int nbad = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  cellprot_ctrl #(
    .SC_TICKS(L_SC), .DOC_TICKS(L_DOC), .UV_TICKS(L_UV), .COC_TICKS(L_COC),
    .OV_TICKS(L_OV), .OVR_TICKS(L_OVR), .UVR_TICKS(L_UVR), .DR_TICKS(L_DR),
    .CR_TICKS(L_CR)
  ) dut (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .us_tick(us_tick),
    .ov_trip(ov_trip), .ov_clear(ov_clear), .uv_trip(uv_trip), .uv_clear(uv_clear),
    .doc_trip(doc_trip), .short_trip(short_trip), .doc_clear(doc_clear),
    .coc_trip(coc_trip), .coc_clear(coc_clear), .low_cell(low_cell),
    .charger_on(charger_on), .load_on(load_on), .chg_en(chg_en), .dsg_en(dsg_en),
    .shutdown(shutdown), .cs_pulldown(cs_pulldown), .cs_pullup(cs_pullup)
  );

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input logic [4:0] exp, input string tag);
    logic [4:0] act;
    act = {chg_en, dsg_en, shutdown, cs_pulldown, cs_pullup};
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: outputs %b, expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    {ov_trip, ov_clear, uv_trip, uv_clear, doc_trip, short_trip, doc_clear} = '0;
    {coc_trip, coc_clear, low_cell, charger_on, load_on} = '0;
    ms_tick = 1'b1;
    us_tick = 1'b1;
    rst_n   = 1'b0;
    cyc(2);
    rst_n = 1'b1;
    cyc(3);
  endtask

  task automatic set_det(input int id, input logic v);
    case (id)
      0: short_trip = v;
      1: doc_trip   = v;
      2: uv_trip    = v;
      3: coc_trip   = v;
      default: ov_trip = v;
    endcase
  endtask

  function automatic int det_lim(input int id);
    case (id)
      0: return L_SC;
      1: return L_DOC;
      2: return L_UV;
      3: return L_COC;
      default: return L_OV;
    endcase
  endfunction

  function automatic logic [4:0] det_out(input int id);
    case (id)
      0, 1: return O_DSG;
      2: return O_UVS;
      3: return O_COC;
      default: return O_OV;
    endcase
  endfunction

  initial begin
    cyc(100000);
    nbad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    do_reset();
    check(O_NORM, "R1 reset state");

    // R2: sweep every hold length below the limit, then restart, then exact trip
    for (int id = 0; id < 5; id++) begin
      for (int n = 1; n < det_lim(id); n++) begin
        do_reset();
        set_det(id, 1'b1);
        cyc(n);
        set_det(id, 1'b0);
        cyc(2);
        check(O_NORM, $sformatf("R2 det%0d short hold %0d", id, n));
      end
      do_reset();
      set_det(id, 1'b1);
      cyc(det_lim(id) - 1);
      set_det(id, 1'b0);
      cyc(1);
      set_det(id, 1'b1);
      cyc(det_lim(id) - 1);
      check(O_NORM, $sformatf("R2 det%0d restart", id));
      cyc(1);
      set_det(id, 1'b0);
      check(det_out(id), $sformatf("R2 det%0d trip", id));
    end

    // R3: over-charge release needs the charger gone
    do_reset();
    charger_on = 1'b1;
    ov_trip = 1'b1; cyc(L_OV); ov_trip = 1'b0;
    check(O_OV, "R3 enter");
    ov_clear = 1'b1; cyc(L_OVR + 3);
    check(O_OV, "R3 hold with charger");
    charger_on = 1'b0; cyc(L_OVR - 1);
    check(O_OV, "R3 before release");
    cyc(1);
    check(O_NORM, "R3 released");
    ov_clear = 1'b0;

    // R4: only short-circuit acts in over-charge
    do_reset();
    ov_trip = 1'b1; cyc(L_OV); ov_trip = 1'b0;
    load_on = 1'b1; doc_trip = 1'b1; cyc(L_DOC + 4); doc_trip = 1'b0;
    check(O_OV, "R4 discharge over-current ignored");
    short_trip = 1'b1; cyc(L_SC - 1);
    check(O_OV, "R4 short not yet");
    cyc(1);
    check(O_OVSC, "R4 short in over-charge");
    short_trip = 1'b0; cyc(3);
    check(O_OVSC, "R4 load still present");
    load_on = 1'b0; cyc(1);
    check(O_OV, "R4 back to over-charge");

    // R5: under-voltage shutdown, wake, lockout, release
    do_reset();
    uv_trip = 1'b1; cyc(L_UV); uv_trip = 1'b0;
    check(O_UVS, "R5 shutdown");
    uv_clear = 1'b1; cyc(6); uv_clear = 1'b0;
    check(O_UVS, "R5 no charger");
    charger_on = 1'b1; cyc(1);
    check(O_UVW, "R5 woken");
    low_cell = 1'b1; cyc(1);
    check(5'b00000, "R8 inhibit in wake");
    low_cell = 1'b0;
    coc_trip = 1'b1; cyc(L_COC + 4); coc_trip = 1'b0;
    check(O_UVW, "R5 charge over-current ignored");
    uv_clear = 1'b1; cyc(L_UVR - 1);
    check(O_UVW, "R5 before release");
    cyc(1);
    check(O_NORM, "R5 released");
    uv_clear = 1'b0; charger_on = 1'b0;

    // R6: discharge over-current and short release
    for (int k = 0; k < 2; k++) begin
      do_reset();
      load_on = 1'b1;
      set_det(k, 1'b1); cyc(det_lim(k)); set_det(k, 1'b0);
      check(O_DSG, "R6 enter");
      low_cell = 1'b1; cyc(1);
      check(5'b00010, "R8 inhibit in discharge fault");
      low_cell = 1'b0;
      doc_clear = 1'b1; cyc(L_DR + 3);
      check(O_DSG, "R6 hold with load");
      load_on = 1'b0; cyc(L_DR - 1);
      check(O_DSG, "R6 before release");
      cyc(1);
      check(O_NORM, "R6 released");
      doc_clear = 1'b0;
    end

    // R7: charge over-current release
    do_reset();
    charger_on = 1'b1;
    coc_trip = 1'b1; cyc(L_COC); coc_trip = 1'b0;
    check(O_COC, "R7 enter");
    coc_clear = 1'b1; cyc(L_CR + 3);
    check(O_COC, "R7 hold with charger");
    charger_on = 1'b0; cyc(L_CR - 1);
    check(O_COC, "R7 before release");
    cyc(1);
    check(O_NORM, "R7 released");
    coc_clear = 1'b0;

    // R8: inhibit in normal mode
    do_reset();
    low_cell = 1'b1; cyc(1);
    check(5'b01000, "R8 inhibit normal");
    low_cell = 1'b0; cyc(1);
    check(O_NORM, "R8 inhibit removed");

    // R9: priority among simultaneous detections
    do_reset();
    doc_trip = 1'b1; uv_trip = 1'b1; coc_trip = 1'b1; ov_trip = 1'b1;
    cyc(4);
    {doc_trip, uv_trip, coc_trip, ov_trip} = '0;
    check(O_DSG, "R9 discharge over-current first");
    do_reset();
    uv_trip = 1'b1; coc_trip = 1'b1; ov_trip = 1'b1;
    cyc(4);
    {uv_trip, coc_trip, ov_trip} = '0;
    check(O_UVS, "R9 under-voltage before charge faults");
    do_reset();
    coc_trip = 1'b1; ov_trip = 1'b1;
    cyc(4);
    {coc_trip, ov_trip} = '0;
    ov_clear = 1'b1; cyc(L_OVR + 2); ov_clear = 1'b0;
    check(O_COC, "R9 charge over-current before over-charge");
    coc_clear = 1'b1; cyc(L_CR); coc_clear = 1'b0;
    check(O_NORM, "R9 released by charge path");

    // R10: counting only on the matching strobe
    do_reset();
    ms_tick = 1'b0;
    ov_trip = 1'b1; cyc(20);
    check(O_NORM, "R10 no millisecond strobe");
    repeat (L_OV - 1) begin
      ms_tick = 1'b1; cyc(1); ms_tick = 1'b0; cyc(2);
    end
    check(O_NORM, "R10 one strobe short");
    ms_tick = 1'b1; cyc(1); ms_tick = 1'b0;
    ov_trip = 1'b0;
    check(O_OV, "R10 strobe limit reached");
    do_reset();
    ms_tick = 1'b0; us_tick = 1'b0;
    short_trip = 1'b1; cyc(10);
    check(O_NORM, "R10 no microsecond strobe");
    us_tick = 1'b1; cyc(L_SC);
    short_trip = 1'b0;
    check(O_DSG, "R10 short on microsecond strobe");

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

endmodule